// File: doc/BRIEF.md
# Zoned Associative Address Translation Lookup

This block translates a virtual address in a single compare cycle by checking it against every entry of a fully associative translation buffer. Each entry holds a tag word (virtual page number, page size code, valid flag), an 8-bit owner task ID and a data word (real page number, write and execute permission, zone select). Pages of eight sizes, from 1 KiB to 16 MiB, can share one array. An entry with task ID zero is global and matches every process.

A 32-bit zone protection word holds a 2-bit code for each of sixteen zones. Depending on the privilege of the access, the code for an entry's zone can hide the entry, keep its own permission bits, or widen them. The lowest-numbered entry that matches and is visible decides the result. The result is a hit, a protection error or a miss, together with the matched index, the physical address, the page size code and the granted permissions, all registered one cycle after the request. The entries are loaded through a simple write port. Refill and exception handling belong to the surrounding logic.

Top module: `tlbz_lookup`

## Requirements
- R1: Pulsing `wr_tag_en` stores `wr_word` as the tag word of entry `wr_idx` and stores `wr_tid` as that entry's task ID. Pulsing `wr_data_en` stores `wr_word` as its data word. A lookup requested in the cycle after the write sees the new contents. Reset clears every entry.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. The response fields belong to that request.
- R3: Tag bits 9:7 hold a size code c, giving a page of 2^(10+2c) bytes (1 KiB up to 16 MiB). The entry's address matches when virtual address bits 31 down to 10+2c equal the same tag bits.
- R4: Only an entry whose tag bit 6 (valid) is set can match.
- R5: A nonzero task ID matches only when it equals `cur_pid`. A task ID of zero matches every process.
- R6: Data bits 7:4 select zone z, whose code is read from `zone_prot` bits [31-2z : 30-2z].
- R7: Data bit 8 is the entry's write permission and bit 9 is its execute permission. Zone code 0 hides the entry from user accesses (`req_user`=1). Code 1 keeps the entry's own bits. Code 2 grants write and execute to privileged accesses only. Code 3 grants both in every mode.
- R8: A zone select above the `ZONE_LIMIT` parameter, or an instance built with `ZONES_ON`=0, is handled as code 1.
- R9: `req_kind` is 0 for read, 1 for write and 2 for fetch. Read is always granted. A write without write permission, or a fetch without execute permission, gives `rsp_status`=2 (protection error). Otherwise the status is 1 (hit). `rsp_perm` is {execute, write, read}, with read in bit 0.
- R10: The visible matching entry with the lowest index is chosen, and its outcome ends the search, even when it is a protection error. Entries hidden by zone code 0 are skipped.
- R11: When no entry is chosen, `rsp_status` is 0 (miss) and the index, address, size and permission outputs are all zero.
- R12: For a chosen entry, `rsp_paddr` takes data bits at and above 10+2c and virtual address bits below 10+2c, and `rsp_size` is c. These outputs are also reported on a protection error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_tag_en | input | 1 | Write tag word and task ID |
| wr_data_en | input | 1 | Write data word |
| wr_idx | input | IDX_W | Entry to write |
| wr_word | input | 32 | Word to store |
| wr_tid | input | 8 | Task ID stored with a tag write |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| cur_pid | input | 8 | Current process ID |
| zone_prot | input | 32 | Zone protection codes |
| rsp_valid | output | 1 | Response valid |
| rsp_status | output | 2 | 0 miss, 1 hit, 2 protection error |
| rsp_idx | output | IDX_W | Chosen entry |
| rsp_paddr | output | 32 | Physical address |
| rsp_size | output | 3 | Page size code |
| rsp_perm | output | 3 | Granted {execute, write, read} |

## Verification
The assertions assume that `req_kind` never takes the value 3, which has no defined meaning. They also assume that the write port and the lookup port are not used in the same cycle, so that each response reflects a settled table. The bench therefore draws every access type from 0 to 2 and spaces writes and lookups on separate cycles. The random table uses a few address bits and task IDs 0 to 2, so that overlapping entries of different sizes and shared global entries appear often.

// File: rtl/tlbz_pkg.sv
package tlbz_pkg;

    localparam int WORD_W     = 32;
    localparam int BASE_SHIFT = 10;
    localparam int VALID_BIT  = 6;
    localparam int SIZE_LSB   = 7;
    localparam int WR_BIT     = 8;
    localparam int EX_BIT     = 9;
    localparam int ZONE_LSB   = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        LK_MISS = 2'd0,
        LK_HIT  = 2'd1,
        LK_PROT = 2'd2
    } lk_e;

    typedef struct packed {
        logic [WORD_W-1:0] tag;
        logic [WORD_W-1:0] data;
        logic [7:0]        tid;
    } entry_t;

    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } perm_t;

    typedef struct packed {
        logic              vis;
        logic              ok;
        perm_t             perm;
        logic [WORD_W-1:0] paddr;
        logic [2:0]        size;
    } res_t;

    function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
        return {WORD_W{1'b1}} << (BASE_SHIFT + 2 * int'(code));
    endfunction

    function automatic logic [1:0] zone_code(input logic [WORD_W-1:0] zp,
                                             input logic [3:0] z);
        logic [WORD_W-1:0] s;
        s = zp >> (30 - 2 * int'(z));
        return s[1:0];
    endfunction

endpackage

// File: rtl/tlbz_store.sv
module tlbz_store
    import tlbz_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_tag_en,
    input  logic        wr_data_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0] wr_word,
    input  logic [7:0]  wr_tid,
    output entry_t      ents [ENTRIES]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ents[i] <= '0;
            end
        end else begin
            if (wr_tag_en) begin
                ents[wr_idx].tag <= wr_word;
                ents[wr_idx].tid <= wr_tid;
            end
            if (wr_data_en) begin
                ents[wr_idx].data <= wr_word;
            end
        end
    end

endmodule

// File: rtl/tlbz_match.sv
module tlbz_match
    import tlbz_pkg::*;
#(
    parameter int ZONE_LIMIT = 15,
    parameter bit ZONES_ON   = 1'b1
) (
    input  entry_t      ent,
    input  logic [31:0] vaddr,
    input  logic [1:0]  kind,
    input  logic        user,
    input  logic [7:0]  pid,
    input  logic [31:0] zp,
    output res_t        res
);

    logic [31:0] mask;
    logic [2:0]  code;
    logic [3:0]  zsel;
    logic [1:0]  zc;
    logic        addr_eq;
    logic        tid_ok;
    logic        w_eff;
    logic        x_eff;
    logic        unused_bits;

    assign unused_bits = ^{ent.tag[VALID_BIT-1:0], ent.data[ZONE_LSB-1:0]};

    always_comb begin
        code    = ent.tag[SIZE_LSB +: 3];
        mask    = page_mask(code);
        zsel    = ent.data[ZONE_LSB +: 4];
        addr_eq = ((vaddr ^ ent.tag) & mask) == '0;
        tid_ok  = (ent.tid == 8'd0) || (ent.tid == pid);

        if (ZONES_ON && (32'(zsel) <= 32'(ZONE_LIMIT))) begin
            zc = zone_code(zp, zsel);
        end else begin
            zc = 2'd1;
        end

        w_eff = ent.data[WR_BIT];
        x_eff = ent.data[EX_BIT];
        if (zc == 2'd3 || (zc == 2'd2 && !user)) begin
            w_eff = 1'b1;
            x_eff = 1'b1;
        end

        res.vis = ent.tag[VALID_BIT] && addr_eq && tid_ok
                  && !(zc == 2'd0 && user);
        unique case (kind)
            ACC_WRITE: res.ok = w_eff;
            ACC_FETCH: res.ok = x_eff;
            default:   res.ok = 1'b1;
        endcase
        res.perm  = '{x: x_eff, w: w_eff, r: 1'b1};
        res.paddr = (ent.data & mask) | (vaddr & ~mask);
        res.size  = code;
    end

endmodule

// File: rtl/tlbz_prio.sv
module tlbz_prio #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] lowest;

    assign lowest = req & (~req + 1'b1);
    assign found  = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (lowest[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tlbz_lookup.sv
module tlbz_lookup
    import tlbz_pkg::*;
#(
    parameter int ENTRIES    = 64,
    parameter int ZONE_LIMIT = 15,
    parameter bit ZONES_ON   = 1'b1,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_tag_en,
    input  logic             wr_data_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_word,
    input  logic [7:0]       wr_tid,
    input  logic             req_valid,
    input  logic [31:0]      req_vaddr,
    input  logic [1:0]       req_kind,
    input  logic             req_user,
    input  logic [7:0]       cur_pid,
    input  logic [31:0]      zone_prot,
    output logic             rsp_valid,
    output logic [1:0]       rsp_status,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [31:0]      rsp_paddr,
    output logic [2:0]       rsp_size,
    output logic [2:0]       rsp_perm
);

    entry_t           ents [ENTRIES];
    res_t             res  [ENTRIES];
    logic [ENTRIES-1:0] vis_vec;
    logic             found;
    logic [IDX_W-1:0] pick;
    res_t             sel;

    tlbz_store #(.ENTRIES(ENTRIES)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_tag_en  (wr_tag_en),
        .wr_data_en (wr_data_en),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .wr_tid     (wr_tid),
        .ents       (ents)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tlbz_match #(.ZONE_LIMIT(ZONE_LIMIT), .ZONES_ON(ZONES_ON)) u_match (
            .ent   (ents[g]),
            .vaddr (req_vaddr),
            .kind  (req_kind),
            .user  (req_user),
            .pid   (cur_pid),
            .zp    (zone_prot),
            .res   (res[g])
        );
        assign vis_vec[g] = res[g].vis;
    end

    tlbz_prio #(.N(ENTRIES)) u_prio (
        .req   (vis_vec),
        .found (found),
        .idx   (pick)
    );

    assign sel = res[pick];

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_status <= LK_MISS;
            rsp_idx    <= '0;
            rsp_paddr  <= '0;
            rsp_size   <= '0;
            rsp_perm   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                if (found) begin
                    rsp_status <= sel.ok ? LK_HIT : LK_PROT;
                    rsp_idx    <= pick;
                    rsp_paddr  <= sel.paddr;
                    rsp_size   <= sel.size;
                    rsp_perm   <= sel.perm;
                end else begin
                    rsp_status <= LK_MISS;
                    rsp_idx    <= '0;
                    rsp_paddr  <= '0;
                    rsp_size   <= '0;
                    rsp_perm   <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/tlbz_chk.sv
module tlbz_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [31:0]      req_vaddr,
    input logic [1:0]       req_kind,
    input logic             rsp_valid,
    input logic [1:0]       rsp_status,
    input logic [IDX_W-1:0] rsp_idx,
    input logic [31:0]      rsp_paddr,
    input logic [2:0]       rsp_size,
    input logic [2:0]       rsp_perm
);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2

    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2

    AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd0) |->
        (rsp_perm == 3'd0 && rsp_idx == '0 && rsp_paddr == 32'd0 && rsp_size == 3'd0)); // R11

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_status != 2'd3); // R9

    AST_READ_GRANTED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> rsp_perm[0]); // R9

    AST_PROT_NOT_READ: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd2) |-> $past(req_kind) != 2'd0); // R9

    AST_HIT_WRITE_OK: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1 && $past(req_kind) == 2'd1) |-> rsp_perm[1]); // R9

    AST_HIT_FETCH_OK: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status == 2'd1 && $past(req_kind) == 2'd2) |-> rsp_perm[2]); // R9

    AST_PADDR_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != 2'd0) |-> rsp_paddr[9:0] == $past(req_vaddr[9:0])); // R12

endmodule

bind tlbz_lookup tlbz_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_kind   (req_kind),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_idx    (rsp_idx),
    .rsp_paddr  (rsp_paddr),
    .rsp_size   (rsp_size),
    .rsp_perm   (rsp_perm)
);

// File: tb/tb_tlbz_lookup.sv
module tb_tlbz_lookup;

    localparam int NE  = 8;
    localparam int LIM = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_tag_en = 1'b0;
    logic        wr_data_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic [7:0]  wr_tid = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic [7:0]  cur_pid = '0;
    logic [31:0] zone_prot = '0;

    logic        rsp_valid, nz_valid;
    logic [1:0]  rsp_status, nz_status;
    logic [2:0]  rsp_idx, nz_idx;
    logic [31:0] rsp_paddr, nz_paddr;
    logic [2:0]  rsp_size, nz_size;
    logic [2:0]  rsp_perm, nz_perm;

    always #5 clk = ~clk;

    tlbz_lookup #(.ENTRIES(NE), .ZONE_LIMIT(LIM), .ZONES_ON(1'b1)) dut (
        .clk, .rst, .wr_tag_en, .wr_data_en, .wr_idx, .wr_word, .wr_tid,
        .req_valid, .req_vaddr, .req_kind, .req_user, .cur_pid, .zone_prot,
        .rsp_valid, .rsp_status, .rsp_idx, .rsp_paddr, .rsp_size, .rsp_perm
    );

    tlbz_lookup #(.ENTRIES(NE), .ZONE_LIMIT(LIM), .ZONES_ON(1'b0)) dut_nz (
        .clk, .rst, .wr_tag_en, .wr_data_en, .wr_idx, .wr_word, .wr_tid,
        .req_valid, .req_vaddr, .req_kind, .req_user, .cur_pid, .zone_prot,
        .rsp_valid (nz_valid), .rsp_status (nz_status), .rsp_idx (nz_idx),
        .rsp_paddr (nz_paddr), .rsp_size (nz_size), .rsp_perm (nz_perm)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] m_tag  [NE];
    logic [31:0] m_data [NE];
    logic [7:0]  m_tid  [NE];

    task automatic cmp(input string lab, input logic [42:0] act, input logic [42:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", lab, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_tag(input logic [31:0] va, input int c, input bit v);
        return (va & 32'hFFFF_FC00) | (32'(c) << 7) | (32'(v) << 6);
    endfunction

    function automatic logic [31:0] mk_data(input logic [31:0] rpn, input bit x,
                                            input bit w, input int z);
        return (rpn & 32'hFFFF_FC00) | (32'(x) << 9) | (32'(w) << 8) | (32'(z) << 4);
    endfunction

    // Expected result {status, idx, paddr, size, perm} from the requirements.
    function automatic logic [42:0] model(input logic [31:0] va, input int kind,
                                          input bit user, input logic [7:0] pid,
                                          input logic [31:0] zp, input bit zon);
        for (int i = 0; i < NE; i++) begin
            int c, sh, z, zc;
            bit w, x, ok;
            logic [31:0] msk;
            if (!m_tag[i][6]) continue;
            c   = int'(m_tag[i][9:7]);
            sh  = 10 + 2 * c;
            msk = 32'hFFFF_FFFF << sh;
            if ((va & msk) != (m_tag[i] & msk)) continue;
            if (m_tid[i] != 8'd0 && m_tid[i] != pid) continue;
            z  = int'(m_data[i][7:4]);
            zc = (zon && z <= LIM) ? int'((zp >> (30 - 2 * z)) & 32'd3) : 1;
            if (zc == 0 && user) continue;
            w = m_data[i][8];
            x = m_data[i][9];
            if (zc == 3 || (zc == 2 && !user)) begin
                w = 1'b1;
                x = 1'b1;
            end
            ok = (kind == 1) ? w : (kind == 2) ? x : 1'b1;
            return {(ok ? 2'd1 : 2'd2), 3'(i), (m_data[i] & msk) | (va & ~msk),
                    3'(c), {x, w, 1'b1}};
        end
        return '0;
    endfunction

    task automatic put_entry(input int i, input logic [31:0] t, input logic [31:0] d,
                             input logic [7:0] id);
        @(negedge clk);
        wr_idx    = 3'(i);
        wr_word   = t;
        wr_tid    = id;
        wr_tag_en = 1'b1;
        @(negedge clk);
        wr_tag_en  = 1'b0;
        wr_word    = d;
        wr_data_en = 1'b1;
        @(negedge clk);
        wr_data_en = 1'b0;
        m_tag[i]  = t;
        m_data[i] = d;
        m_tid[i]  = id;
    endtask

    task automatic look(input string lab, input logic [31:0] va, input int kind,
                        input bit user, input logic [7:0] pid, input logic [31:0] zp);
        @(negedge clk);
        req_vaddr = va;
        req_kind  = 2'(kind);
        req_user  = user;
        cur_pid   = pid;
        zone_prot = zp;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cmp({lab, " R2 valid"}, 43'(rsp_valid), 43'd1);
        cmp(lab, {rsp_status, rsp_idx, rsp_paddr, rsp_size, rsp_perm},
            model(va, kind, user, pid, zp, 1'b1));
        cmp({lab, " R8 zones off"}, {nz_status, nz_idx, nz_paddr, nz_size, nz_perm},
            model(va, kind, user, pid, zp, 1'b0));
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            m_tag[i]  = '0;
            m_data[i] = '0;
            m_tid[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 / R2: reset state
        cmp("R11 reset outputs", {rsp_status, rsp_idx, rsp_paddr, rsp_size, rsp_perm}, '0);
        cmp("R2 reset valid", 43'(rsp_valid), 43'd0);

        // R4: invalid entry never matches
        put_entry(0, mk_tag(32'h1000_0000, 1, 1'b0), mk_data(32'h8000_0000, 1, 1, 0), 8'd0);
        look("R4 invalid entry", 32'h1000_0123, 0, 1'b0, 8'd0, 32'h4000_0000);
        @(negedge clk);
        cmp("R2 valid drops", 43'(rsp_valid), 43'd0);

        // R3 / R12: size sweep with boundary probes
        for (int c = 0; c < 8; c++) begin
            logic [31:0] sz;
            sz = 32'd1 << (10 + 2 * c);
            put_entry(0, mk_tag(32'h2000_0000, c, 1'b1), mk_data(32'hABCD_EC00, 1, 1, 0), 8'd0);
            look("R3 last byte", 32'h2000_0000 + sz - 1, 0, 1'b0, 8'd0, 32'h4000_0000);
            look("R3 next page", 32'h2000_0000 + sz, 0, 1'b0, 8'd0, 32'h4000_0000);
            look("R12 paddr", 32'h2000_0000 + (sz >> 1) + 32'h15, 2, 1'b1, 8'd0, 32'h4000_0000);
        end

        // R1: rewrite of the data word is seen by the next lookup
        put_entry(0, mk_tag(32'h2000_0000, 2, 1'b1), mk_data(32'h1234_4000, 0, 1, 0), 8'd0);
        look("R1 new data", 32'h2000_1234, 1, 1'b0, 8'd0, 32'h4000_0000);

        // R5: task ID matching
        put_entry(1, mk_tag(32'h3000_0000, 2, 1'b1), mk_data(32'h0050_0000, 0, 0, 0), 8'd5);
        put_entry(2, mk_tag(32'h3100_0000, 2, 1'b1), mk_data(32'h0060_0000, 0, 0, 0), 8'd0);
        look("R5 own task", 32'h3000_0040, 0, 1'b1, 8'd5, 32'h4000_0000);
        look("R5 other task", 32'h3000_0040, 0, 1'b1, 8'd6, 32'h4000_0000);
        look("R5 global entry", 32'h3100_0040, 0, 1'b1, 8'd9, 32'h4000_0000);

        // R6 / R7 / R9: every zone, code, permission pair, mode and access type
        for (int z = 0; z <= LIM; z++) begin
            for (int ew = 0; ew < 4; ew++) begin
                put_entry(3, mk_tag(32'h4000_0000, 1, 1'b1),
                          mk_data(32'h0070_0000, ew[1], ew[0], z), 8'd0);
                for (int code = 0; code < 4; code++) begin
                    for (int u = 0; u < 2; u++) begin
                        for (int k = 0; k < 3; k++) begin
                            look("R7 zone sweep", 32'h4000_0ABC, k, u[0], 8'd1,
                                 (32'(code) << (30 - 2 * z)) | 32'h0000_0001);
                        end
                    end
                end
            end
        end

        // R8: zone select above the limit acts as code 1
        put_entry(3, mk_tag(32'h4000_0000, 1, 1'b1), mk_data(32'h0070_0000, 0, 0, 13), 8'd0);
        look("R8 zone 13 user read", 32'h4000_0100, 0, 1'b1, 8'd1, 32'h0);
        look("R8 zone 13 priv write", 32'h4000_0100, 1, 1'b0, 8'd1, 32'hFFFF_FFFF);
        put_entry(3, mk_tag(32'h4000_0000, 1, 1'b1), mk_data(32'h0070_0000, 1, 0, 12), 8'd0);
        look("R8 zone 12 fetch", 32'h4000_0100, 2, 1'b1, 8'd1, 32'h0);

        // R10: priority among overlapping entries
        put_entry(4, mk_tag(32'h5000_0000, 3, 1'b1), mk_data(32'h0A00_0000, 0, 0, 1), 8'd0);
        put_entry(5, mk_tag(32'h5000_0000, 4, 1'b1), mk_data(32'h0B00_0000, 1, 1, 2), 8'd0);
        look("R10 lowest wins", 32'h5000_0200, 0, 1'b0, 8'd0, 32'h1400_0000);
        look("R10 hidden skipped", 32'h5000_0200, 0, 1'b1, 8'd0, 32'h0400_0000);
        look("R10 prot stops search", 32'h5000_0200, 1, 1'b1, 8'd0, 32'h1400_0000);

        // R11: nothing matches
        look("R11 miss", 32'h7000_0000, 2, 1'b0, 8'd3, 32'hFFFF_FFFF);

        // R9 / R10: dense random tables
        for (int round = 0; round < 150; round++) begin
            for (int i = 0; i < NE; i++) begin
                put_entry(i, mk_tag($urandom & 32'h0301_0C00, $urandom_range(0, 7),
                                    $urandom_range(0, 3) != 0),
                          $urandom, 8'($urandom_range(0, 2)));
            end
            for (int j = 0; j < 20; j++) begin
                look("R9 random table", $urandom & 32'h0301_0FFF, $urandom_range(0, 2),
                     $urandom_range(0, 1) != 0, 8'($urandom_range(0, 2)), $urandom);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule